// File: doc/BRIEF.md
# Offset-Cancelling Result Averager

This datapath turns a stream of raw signed internal conversion values into output results and labels each result as trustworthy or not. Each raw sample arrives with a one-cycle strobe, together with the channel code, the speed code and the mode bit it was taken with. The block drives a polarity output that tells the sampling front end which input polarity to use for the next conversion. The polarity alternates on every accepted sample. Every result is the halved difference between a positive-polarity sample and a reversed-polarity sample, so a constant offset common to both samples cancels out.

In the single-rate mode, samples are consumed in pairs and a result appears after every second sample. In the double-rate mode, each new sample is combined with the one before it as a running average, so a result appears for every sample. A validity flag goes with each result. It is cleared only where the double-rate mode has just combined samples from two different channels. A speed code of zero means "keep the speed in use".

Top module: `offset_avg`

## Requirements
- R1: While reset is asserted, and after it until the first sample, out_valid_o, result_ok_o and result_o are 0 and polarity_o is 0, where 0 means positive polarity.
- R2: polarity_o inverts after each accepted sample (sample_valid_i high at a clock edge) and holds otherwise; every sample counts as taken with the polarity_o value present when it arrives.
- R3: The result is (P - R) >>> 1, with P the positive-polarity sample and R the reversed-polarity sample. It is computed on a 25-bit sign-extended difference, floor-rounded, and never wraps, including the extreme pair 0x7FFFFF/0x800000.
- R4: In single-rate mode (mode_2x_i = 0) every result has result_ok_o = 1, including the first result after a channel or speed change.
- R5: In single-rate mode a sample with no open pair opens one and produces no result. The next single-rate sample closes the pair and produces a result, unless its channel or effective speed differs from the open sample's; in that case the open sample is dropped and the new sample opens a fresh pair.
- R6: In double-rate mode (mode_2x_i = 1) every sample except the first since reset produces a result combining it with the immediately preceding sample.
- R7: In double-rate mode a result whose sample's channel differs from the preceding sample's channel has result_ok_o = 0; later results on the same channel have result_ok_o = 1.
- R8: In double-rate mode a change of speed alone leaves result_ok_o = 1.
- R9: Switching mode without a channel change gives a valid first result: the first double-rate sample combines with the last single-rate sample, and after a switch to single rate the pairing restarts.
- R10: A speed code of 0 keeps the effective speed, starting at the reset default 3, and does not count as a speed change.
- R11: A result appears exactly one clock after its sample as a one-cycle out_valid_o pulse; result_o and result_ok_o hold their values until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sample_valid_i | input | 1 | Raw sample strobe |
| sample_i | input | 24 | Raw signed conversion value |
| chan_i | input | 4 | Channel code of the sample |
| speed_i | input | 4 | Speed code, 0 keeps the current speed |
| mode_2x_i | input | 1 | 1 selects double-rate running average |
| polarity_o | output | 1 | Polarity for the next sample, 1 means reversed |
| out_valid_o | output | 1 | One-cycle result strobe |
| result_o | output | 24 | Signed result |
| result_ok_o | output | 1 | Result validity flag |

## Verification
If the polarity or pair state is wrong, the next result either shows the wrong sign or appears on the wrong sample; both show up within two strobes. A stale channel or speed register shows up as a missing or extra result, or a wrong validity flag, on the first sample after a change. The sweeps mix channel changes, speed changes, zero speed codes and mode switches over many sample values, so every such mismatch reaches a port check within one result.

// File: rtl/avg_pkg.sv
package avg_pkg;
  typedef enum logic {
    POL_POS = 1'b0,
    POL_REV = 1'b1
  } pol_e;
endpackage

// File: rtl/avg_cfg_track.sv
module avg_cfg_track #(
  parameter int CHAN_W    = 4,
  parameter int SPEED_W   = 4,
  parameter int CHAN_RST  = 0,
  parameter int SPEED_RST = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               take_i,
  input  logic [CHAN_W-1:0]  chan_i,
  input  logic [SPEED_W-1:0] speed_i,
  output logic               chan_chg_o,
  output logic               spd_chg_o
);
  localparam logic [CHAN_W-1:0]  CHAN_INIT = CHAN_W'(CHAN_RST);
  localparam logic [SPEED_W-1:0] SPD_INIT  = SPEED_W'(SPEED_RST);

  logic [CHAN_W-1:0]  chan_q;
  logic [SPEED_W-1:0] eff_q, eff_d;

  // zero speed code keeps the speed in use
  assign eff_d      = (speed_i == '0) ? eff_q : speed_i;
  assign chan_chg_o = (chan_i != chan_q);
  assign spd_chg_o  = (eff_d != eff_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_q <= CHAN_INIT;
      eff_q  <= SPD_INIT;
    end else if (take_i) begin
      chan_q <= chan_i;
      eff_q  <= eff_d;
    end
  end

  a_r10_zero_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && speed_i == '0) |=> $stable(eff_q));
  a_r10_load_speed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && speed_i != '0) |=> (eff_q == $past(speed_i)));
endmodule

// File: rtl/avg_sample_store.sv
module avg_sample_store
  import avg_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              mode_2x_i,
  input  logic              brk_i,
  output pol_e              pol_o,
  output logic [DATA_W-1:0] prev_o,
  output pol_e              prev_pol_o,
  output logic              have_prev_o,
  output logic              pair_open_o
);
  pol_e              pol_q, prev_pol_q;
  logic [DATA_W-1:0] prev_q;
  logic              have_q, open_q, open_d;

  // single rate: close an open pair unless config broke it
  assign open_d = mode_2x_i ? 1'b0 : !(open_q && !brk_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_q      <= POL_POS;
      prev_pol_q <= POL_POS;
      prev_q     <= '0;
      have_q     <= 1'b0;
      open_q     <= 1'b0;
    end else if (take_i) begin
      pol_q      <= (pol_q == POL_POS) ? POL_REV : POL_POS;
      prev_pol_q <= pol_q;
      prev_q     <= sample_i;
      have_q     <= 1'b1;
      open_q     <= open_d;
    end
  end

  assign pol_o       = pol_q;
  assign prev_o      = prev_q;
  assign prev_pol_o  = prev_pol_q;
  assign have_prev_o = have_q;
  assign pair_open_o = open_q;

  a_r2_pol_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> (pol_q != $past(pol_q)));
  a_r2_pol_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_i |=> $stable(pol_q));
  a_r6_prev_opposite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    have_q |-> (prev_pol_q != pol_q));
endmodule

// File: rtl/avg_combiner.sv
module avg_combiner
  import avg_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic [DATA_W-1:0] prev_i,
  input  pol_e              prev_pol_i,
  input  logic [DATA_W-1:0] cur_i,
  output logic [DATA_W-1:0] half_o
);
  localparam int SUM_W = DATA_W + 1;

  logic signed [SUM_W-1:0] pos_x, rev_x, diff;

  always_comb begin
    if (prev_pol_i == POL_POS) begin
      pos_x = {prev_i[DATA_W-1], prev_i};
      rev_x = {cur_i[DATA_W-1], cur_i};
    end else begin
      pos_x = {cur_i[DATA_W-1], cur_i};
      rev_x = {prev_i[DATA_W-1], prev_i};
    end
    diff = pos_x - rev_x;
  end

  // arithmetic halve: drop the lsb of the widened difference
  assign half_o = diff[SUM_W-1:1];
endmodule

// File: rtl/offset_avg.sv
module offset_avg
  import avg_pkg::*;
#(
  parameter int DATA_W    = 24,
  parameter int CHAN_W    = 4,
  parameter int SPEED_W   = 4,
  parameter int SPEED_RST = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sample_valid_i,
  input  logic [DATA_W-1:0]  sample_i,
  input  logic [CHAN_W-1:0]  chan_i,
  input  logic [SPEED_W-1:0] speed_i,
  input  logic               mode_2x_i,
  output logic               polarity_o,
  output logic               out_valid_o,
  output logic [DATA_W-1:0]  result_o,
  output logic               result_ok_o
);
  logic              chan_chg, spd_chg, brk;
  pol_e              pol, prev_pol;
  logic [DATA_W-1:0] prev, half;
  logic              have_prev, pair_open, emit, ok_d;

  avg_cfg_track #(
    .CHAN_W(CHAN_W), .SPEED_W(SPEED_W), .CHAN_RST(0), .SPEED_RST(SPEED_RST)
  ) u_cfg (
    .clk_i, .rst_ni, .take_i(sample_valid_i), .chan_i, .speed_i,
    .chan_chg_o(chan_chg), .spd_chg_o(spd_chg)
  );

  assign brk = chan_chg || spd_chg;

  avg_sample_store #(.DATA_W(DATA_W)) u_store (
    .clk_i, .rst_ni, .take_i(sample_valid_i), .sample_i, .mode_2x_i,
    .brk_i(brk), .pol_o(pol), .prev_o(prev), .prev_pol_o(prev_pol),
    .have_prev_o(have_prev), .pair_open_o(pair_open)
  );

  avg_combiner #(.DATA_W(DATA_W)) u_comb (
    .prev_i(prev), .prev_pol_i(prev_pol), .cur_i(sample_i), .half_o(half)
  );

  assign emit = sample_valid_i && (mode_2x_i ? have_prev : (pair_open && !brk));
  assign ok_d = mode_2x_i ? !chan_chg : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      result_o    <= '0;
      result_ok_o <= 1'b0;
    end else begin
      out_valid_o <= emit;
      if (emit) begin
        result_o    <= half;
        result_ok_o <= ok_d;
      end
    end
  end

  assign polarity_o = (pol == POL_REV);

  a_r11_after_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(sample_valid_i));
  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> ($stable(result_o) && $stable(result_ok_o)));
  a_r4_single_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !$past(mode_2x_i)) |-> result_ok_o);
  a_r5_open_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && !mode_2x_i && !pair_open) |=> !out_valid_o);
  a_r7_chan_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && mode_2x_i && have_prev && chan_chg) |=> (out_valid_o && !result_ok_o));
  a_r8_speed_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && mode_2x_i && have_prev && !chan_chg) |=> (out_valid_o && result_ok_o));
endmodule

// File: tb/offset_avg_tb_top.sv
module offset_avg_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sample_valid_i = 1'b0;
  logic [23:0] sample_i = '0;
  logic [3:0]  chan_i = '0;
  logic [3:0]  speed_i = '0;
  logic        mode_2x_i = 1'b0;
  logic        polarity_o, out_valid_o, result_ok_o;
  logic [23:0] result_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference state
  bit          m_pol, m_lpol, m_have, m_open;
  logic [23:0] m_last, m_res;
  logic [3:0]  m_chan, m_spd;
  bit          m_ok;

  always #10 clk_i = ~clk_i;

  offset_avg dut_i (
    .clk_i, .rst_ni, .sample_valid_i, .sample_i, .chan_i, .speed_i, .mode_2x_i,
    .polarity_o, .out_valid_o, .result_o, .result_ok_o
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [23:0] half_diff(input logic [23:0] p, input logic [23:0] r);
    longint d;
    d = longint'($signed(p)) - longint'($signed(r));
    return 24'(d >>> 1);
  endfunction

  task automatic send(input logic [23:0] v, input logic [3:0] ch, input logic [3:0] sp,
                      input bit m2, input string tag);
    logic [3:0] eff;
    bit brk, e_emit, e_ok;
    logic [23:0] e_res;
    eff = (sp == 4'd0) ? m_spd : sp;
    brk = (ch != m_chan) || (eff != m_spd);
    chk("R2", "polarity", polarity_o, m_pol);
    if (m2) begin
      e_emit = m_have;
      e_ok   = (ch == m_chan);
    end else begin
      e_emit = m_open && !brk;
      e_ok   = 1'b1;
    end
    e_res = m_lpol ? half_diff(v, m_last) : half_diff(m_last, v);
    sample_i = v; chan_i = ch; speed_i = sp; mode_2x_i = m2; sample_valid_i = 1'b1;
    @(negedge clk_i);
    sample_valid_i = 1'b0;
    chk(tag, "out_valid", out_valid_o, e_emit);
    if (e_emit) begin
      chk(tag, "result", result_o, e_res);
      chk(tag, "ok_flag", result_ok_o, e_ok);
      m_res = e_res; m_ok = e_ok;
    end
    m_open = m2 ? 1'b0 : !(m_open && !brk);
    m_lpol = m_pol; m_pol = !m_pol; m_last = v; m_have = 1'b1;
    m_chan = ch; m_spd = eff;
    @(negedge clk_i);
    chk("R11", "pulse_end", out_valid_o, 0);
    chk("R11", "result_hold", result_o, m_res);
    chk("R11", "ok_hold", result_ok_o, m_ok);
  endtask

  function automatic logic [23:0] val(input int k);
    return 24'((k * 40503 + 12345) ^ (k << 13));
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL R11 watchdog actual=hang expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    m_pol = 0; m_lpol = 0; m_have = 0; m_open = 0; m_last = '0;
    m_chan = 4'd0; m_spd = 4'd3; m_res = '0; m_ok = 0;
    repeat (3) @(negedge clk_i);
    chk("R1", "out_valid_rst", out_valid_o, 0);
    chk("R1", "result_rst", result_o, 0);
    chk("R1", "ok_rst", result_ok_o, 0);
    chk("R1", "pol_rst", polarity_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "out_valid_idle", out_valid_o, 0);
    chk("R1", "pol_idle", polarity_o, 0);

    // single-rate pairs over channels and values
    for (int ch = 0; ch < 4; ch++)
      for (int k = 0; k < 8; k++) begin
        send(val(ch * 16 + 2 * k), 4'(ch), 4'd0, 1'b0, "R3");
        send(val(ch * 16 + 2 * k + 1), 4'(ch), 4'd0, 1'b0, "R4");
      end
    send(24'h7FFFFF, 4'd1, 4'd0, 1'b0, "R3");
    send(24'h800000, 4'd1, 4'd0, 1'b0, "R3");
    send(24'h800000, 4'd1, 4'd0, 1'b0, "R3");
    send(24'h7FFFFF, 4'd1, 4'd0, 1'b0, "R3");
    send(24'h000001, 4'd1, 4'd0, 1'b0, "R3");
    send(24'h000000, 4'd1, 4'd0, 1'b0, "R3");

    // pair breaking
    send(val(200), 4'd1, 4'd0, 1'b0, "R5");
    send(val(201), 4'd2, 4'd0, 1'b0, "R5");
    send(val(202), 4'd2, 4'd0, 1'b0, "R5");
    send(val(203), 4'd2, 4'd5, 1'b0, "R5");
    send(val(204), 4'd2, 4'd6, 1'b0, "R5");
    send(val(205), 4'd2, 4'd0, 1'b0, "R10");
    send(val(206), 4'd2, 4'd6, 1'b0, "R10");
    send(val(207), 4'd2, 4'd0, 1'b0, "R10");
    send(val(208), 4'd3, 4'd9, 1'b0, "R4");
    send(val(209), 4'd3, 4'd9, 1'b0, "R4");

    // double-rate running average: channel and speed changes
    for (int i = 0; i < 40; i++)
      send(val(300 + i), 4'((i / 5) % 4), 4'd0, 1'b1, "R7");
    for (int i = 0; i < 30; i++)
      send(val(400 + i), 4'd2, ((i % 3) == 1) ? 4'((i % 9) + 1) : 4'd0, 1'b1, "R8");
    send(24'h7FFFFF, 4'd2, 4'd0, 1'b1, "R6");
    send(24'h800000, 4'd2, 4'd0, 1'b1, "R6");
    send(24'h7FFFFF, 4'd2, 4'd0, 1'b1, "R6");

    // mode switches
    for (int r = 0; r < 6; r++) begin
      send(val(500 + 8 * r), 4'd1, 4'd0, 1'b0, "R9");
      send(val(501 + 8 * r), 4'd1, 4'd0, 1'b0, "R9");
      if (r % 2 == 1) send(val(502 + 8 * r), 4'd1, 4'd0, 1'b0, "R9");
      send(val(503 + 8 * r), 4'd1, 4'd0, 1'b1, "R9");
      send(val(504 + 8 * r), 4'd1, 4'd7, 1'b1, "R9");
      send(val(505 + 8 * r), 4'd1, 4'd0, 1'b0, "R9");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule